// File: doc/BRIEF.md
# UART Status Flag Register

This block keeps the six status flags of an asynchronous serial port. The transmitter, the receiver and the CPU all act on them. The transmitter sends one-cycle strobes: holding data moved into the shift register, final bit of a character shifted out, and transmit enable switched off. The receiver strobes the end of each frame and supplies the received data bits, the parity bit and the sampled stop bit. From these the block sets the receive-full flag and the three error flags, and it decides whether the receive data register may capture the new byte.

Software sees the flags as one status byte on a register bus. Hardware can clear a flag by its own events, such as a write to the transmit holding register or a read of the receive data register. Software can clear a flag in only one way. It must first read the status byte while the flag is 1, and later write a 0 to that flag's position. The block remembers which flags were seen as 1 by keeping an arm bit for each clearable flag.

Top module: `uart_stat_flags`

## Requirements
- R1: The status byte is laid out as follows: bit 7 transmit-empty, bit 6 receive-full, bit 5 overrun, bit 4 framing error, bit 3 parity error, bit 2 transmit-end, and bits 1..0 always 0. After a synchronous reset with `rst_n` low it reads 0x84.
- R2: A status write clears a flag in bits 7..3 only where the written bit is 0 and that flag is armed. A status read arms each flag that reads 1 and disarms each flag that reads 0. Any clearing of a flag also disarms it. Writing a 1 has no effect. Writing to bits 2..0 has no effect.
- R3: Transmit-empty is set by `tx_load` or `tx_en_off`. It is cleared by `tdr_wr` or by the software clear.
- R4: Transmit-end is set by `tx_en_off`, or by `tx_last_bit` while transmit-empty is 1. `tx_last_bit` while transmit-empty is 0 has no effect. Transmit-end is cleared by `tdr_wr` or by the software clear of transmit-empty.
- R5: A frame that ends with receive-full at 0, stop bit 1 and correct parity sets receive-full and pulses `rx_load`. Receive-full is cleared by `rdr_rd` or by the software clear.
- R6: A frame that ends while receive-full is 1 sets overrun, keeps receive-full at 1 and gives no `rx_load`. Stop and parity are not checked for that frame.
- R7: A frame that ends with a stop bit of 0 while receive-full is 0 sets framing error. It gives no `rx_load`, and receive-full stays 0.
- R8: Parity error is set when the XOR of the data bits and the parity bit differs from `par_odd`. `par_odd` = 0 selects even parity and 1 selects odd parity. Such a frame gives no `rx_load`.
- R9: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: The flags change at the clock edge that samples the strobe. `rx_load` is combinational in the same cycle as `rx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_load | input | 1 | Holding data moved into the shift register |
| tx_last_bit | input | 1 | Final bit of a character shifted out |
| tx_en_off | input | 1 | Transmit enable switched off |
| tdr_wr | input | 1 | CPU wrote the transmit holding register |
| rx_done | input | 1 | Receiver finished a frame |
| rx_data | input | DW | Received data bits |
| rx_par | input | 1 | Received parity bit |
| rx_stop | input | 1 | Sampled stop bit |
| par_odd | input | 1 | Parity mode: 0 even, 1 odd |
| rdr_rd | input | 1 | CPU read the receive data register |
| bus_rd | input | 1 | Status byte read strobe |
| bus_wr | input | 1 | Status byte write strobe |
| bus_wdata | input | 8 | Status write data |
| rdata | output | 8 | Status byte readback |
| rx_load | output | 1 | Receive data register may capture `rx_data` |
| tx_empty | output | 1 | Transmit-empty flag |
| rx_full | output | 1 | Receive-full flag |
| err_ovr | output | 1 | Overrun flag |
| err_frm | output | 1 | Framing error flag |
| err_par | output | 1 | Parity error flag |
| tx_end | output | 1 | Transmit-end flag |

## Verification
The bench builds the block with the default of eight data bits. With eight bits, a frame byte of 0x35 combined with the parity bit gives a known count of ones, so one data pattern can produce a good frame or a parity error under both even and odd mode. The default width also makes it possible to arm all five clearable flags at once and clear them with a single write. It then covers the cases where an arm must not fire: a write without a prior read, and a read that was followed by a hardware clear.

// File: rtl/uart_stat_flags.sv
module uart_stat_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_load,
  input  logic          tx_last_bit,
  input  logic          tx_en_off,
  input  logic          tdr_wr,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_par,
  input  logic          rx_stop,
  input  logic          par_odd,
  input  logic          rdr_rd,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    rdata,
  output logic          rx_load,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          err_ovr,
  output logic          err_frm,
  output logic          err_par,
  output logic          tx_end
);

  logic [4:0] flg, arm, flg_nxt, arm_nxt, hw_set, hw_clr, sw_clr;
  logic       end_nxt, par_ok, fresh;

  assign par_ok  = ((^rx_data) ^ rx_par) == par_odd;
  assign fresh   = rx_done & ~flg[3];
  assign rx_load = fresh & rx_stop & par_ok;

  assign hw_set = {tx_load | tx_en_off, rx_load, rx_done & flg[3],
                   fresh & ~rx_stop, fresh & ~par_ok};
  assign hw_clr = {tdr_wr, rdr_rd, 3'b000};
  assign sw_clr = {5{bus_wr}} & ~bus_wdata[7:3] & arm;

  assign flg_nxt = hw_set | (flg & ~(hw_clr | sw_clr));
  assign arm_nxt = (bus_rd ? flg : arm) & flg_nxt;
  assign end_nxt = tx_en_off | (tx_last_bit & flg[4]) |
                   (tx_end & ~(tdr_wr | sw_clr[4]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg    <= 5'b10000;
      arm    <= '0;
      tx_end <= 1'b1;
    end else begin
      flg    <= flg_nxt;
      arm    <= arm_nxt;
      tx_end <= end_nxt;
    end
  end

  assign {tx_empty, rx_full, err_ovr, err_frm, err_par} = flg;
  assign rdata = {flg, tx_end, 2'b00};

endmodule

module uart_stat_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_load,
  input logic       tx_en_off,
  input logic       rx_done,
  input logic       rdr_rd,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic       rx_load,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       err_ovr,
  input logic       tx_end
);

  a_r3_empty_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load || tx_en_off) |=> tx_empty);

  a_r4_end_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_off |=> tx_end);

  a_r5_full_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (rdr_rd && !rx_done) |=> !rx_full);

  a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full) |=> (err_ovr && rx_full));

  a_r6_no_load_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |-> !rx_full);

  a_r2_ovr_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_ovr) |-> $past(bus_wr && !bus_wdata[5]));

endmodule

bind uart_stat_flags uart_stat_flags_chk u_chk (.*);

// File: tb/sim_uart_stat_flags.sv
`timescale 1ns/100ps
module sim_uart_stat_flags;
  logic clk = 0, rst_n = 0;
  logic tx_load = 0, tx_last_bit = 0, tx_en_off = 0, tdr_wr = 0;
  logic rx_done = 0, rx_par = 0, rx_stop = 1, par_odd = 0, rdr_rd = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] rx_data = 8'h35, bus_wdata = 0;
  logic [7:0] rdata;
  logic rx_load, tx_empty, rx_full, err_ovr, err_frm, err_par, tx_end;
  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit finished = 0;

  always #2 clk = ~clk;

  uart_stat_flags #(.DW(8)) u0 (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #2;
    tx_load = 0; tx_last_bit = 0; tx_en_off = 0; tdr_wr = 0;
    rx_done = 0; rdr_rd = 0; bus_rd = 0; bus_wr = 0;
  endtask

  initial forever begin
    @(posedge clk); #1;
    if (exp_q.size() > 0) chk(rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(8'h84, "R1 reset value");
    cyc(8'h84, "R1 reset value");
    rst_n = 1;
    cyc(8'h84, "R1 idle after reset");
    bus_wr = 1; bus_wdata = 8'h00; cyc(8'h84, "R2 write 0 without read ignored");
    tdr_wr = 1; cyc(8'h00, "R3 R4 holding write clears empty and end");
    tx_last_bit = 1; cyc(8'h00, "R4 last bit with empty=0 ignored");
    tx_load = 1; cyc(8'h80, "R3 load sets empty");
    tx_last_bit = 1; cyc(8'h84, "R4 last bit sets end");
    bus_rd = 1; cyc(8'h84, "R2 read arms");
    bus_wr = 1; bus_wdata = 8'hFF; cyc(8'h84, "R2 write 1 ignored");
    bus_wr = 1; bus_wdata = 8'h7F; cyc(8'h00, "R2 R4 armed clear of empty also clears end");
    tx_en_off = 1; cyc(8'h84, "R3 R4 enable off sets empty and end");

    rx_data = 8'h35; rx_par = 0; par_odd = 0; rx_stop = 1; rx_done = 1; #0.1;
    chk({7'd0, rx_load}, 8'h01, "R5 R10 rx_load on good frame");
    cyc(8'hC4, "R5 good frame sets full");
    rx_done = 1; #0.1;
    chk({7'd0, rx_load}, 8'h00, "R6 no rx_load on overrun");
    cyc(8'hE4, "R6 overrun keeps full");
    rdr_rd = 1; cyc(8'hA4, "R5 data read clears full");
    rx_stop = 0; rx_done = 1; #0.1;
    chk({7'd0, rx_load}, 8'h00, "R7 no rx_load on stop 0");
    cyc(8'hB4, "R7 framing error");
    rx_stop = 1; rx_par = 1; rx_done = 1; #0.1;
    chk({7'd0, rx_load}, 8'h00, "R8 no rx_load on parity error");
    cyc(8'hBC, "R8 even parity mismatch");
    par_odd = 1; rx_done = 1; #0.1;
    chk({7'd0, rx_load}, 8'h01, "R8 odd parity accepted");
    cyc(8'hFC, "R8 odd mode good frame");
    bus_rd = 1; cyc(8'hFC, "R2 read arms all");
    rdr_rd = 1; cyc(8'hBC, "R5 data read clears full");
    rx_done = 1; cyc(8'hFC, "R5 full set again");
    bus_wr = 1; bus_wdata = 8'hBF; cyc(8'hFC, "R2 arm lost after hardware clear");
    bus_wr = 1; bus_wdata = 8'hC7; cyc(8'hC4, "R2 clear three errors, low bits read-only");
    rx_done = 1; cyc(8'hE4, "R6 second overrun");
    bus_rd = 1; cyc(8'hE4, "R2 read arms overrun");
    bus_wr = 1; bus_wdata = 8'hDF; rx_done = 1; cyc(8'hE4, "R9 set wins over clear");
    bus_wr = 1; bus_wdata = 8'hDF; cyc(8'hC4, "R2 armed clear of overrun");
    rst_n = 0; cyc(8'h84, "R1 reset mid-run");
    rst_n = 1; cyc(8'h84, "R1 after reset");
    @(posedge clk); #3;
    finish_run();
  end
endmodule